// File: doc/BRIEF.md
# DAC Channel Sync Arming Controller

This block issues a single-cycle realignment pulse, `dac_sync_pulse`, in the DAC clock domain. All DAC channels in the instance use this pulse to restart in step. The same pulse can be wired across several instances so that they restart together. Software can request the pulse directly. It can also arm the block so that the pulse fires on the next rising edge of an asynchronous external trigger.

Control arrives as single-cycle strobes in the register clock domain: sync, arm, disarm and manual request. The strobes present in one register cycle are captured together into a held command word. One toggle flag carries that word into the DAC domain, so strobes written together take effect in the same DAC cycle. The armed state is resynchronised back into the register domain as a waiting flag. A manual request strobe produces a one-cycle pulse that the surrounding fabric may route back as an external trigger. A build parameter removes the whole external-trigger path.

Top module: `dac_sync_arm`

## Requirements
- R1: A sync strobe produces exactly one `dac_sync_pulse`, one DAC cycle wide. This happens whether or not the block is armed.
- R2: An arm strobe sets `reg_waiting` to 1, and it stays 1 until the trigger fires, a disarm arrives or the DAC side is reset.
- R3: While armed, a low-to-high transition of `ext_sync_in` (after a two-stage synchroniser) produces one `dac_sync_pulse`. The armed state clears on the clock edge that raises the pulse. An input that is already high when arming completes does not fire; only a later rising edge does.
- R4: A disarm strobe returns the block to idle. A later rising edge on `ext_sync_in` then produces no pulse.
- R5: When arm and disarm are strobed in the same register cycle, disarm wins and the block ends idle.
- R6: A manual request strobe produces exactly one `dac_manual_req` pulse, one DAC cycle wide, and no `dac_sync_pulse` of its own.
- R7: With `EXT_SYNC_EN` = 0, the arm, disarm and manual strobes are ignored, and `reg_waiting` and `dac_manual_req` stay 0. The external input never produces a pulse. Sync strobes still work.
- R8: A rising edge on `ext_sync_in` while idle produces no pulse.
- R9: While `dac_rst` is high, the block is idle and `dac_sync_pulse` and `dac_manual_req` are 0. An arm that was pending before a DAC-side reset is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register-side clock |
| reg_rst | input | 1 | Synchronous active-high reset, register side |
| reg_sync_stb | input | 1 | Request an immediate channel sync |
| reg_arm_stb | input | 1 | Arm the external trigger |
| reg_disarm_stb | input | 1 | Cancel a pending arm |
| reg_manual_stb | input | 1 | Emit a manual external-sync request |
| reg_waiting | output | 1 | Armed and waiting for the trigger (register domain) |
| dac_clk | input | 1 | DAC interface clock |
| dac_rst | input | 1 | Synchronous active-high reset, DAC side |
| ext_sync_in | input | 1 | Asynchronous external trigger |
| dac_sync_pulse | output | 1 | One-cycle channel realignment pulse |
| dac_manual_req | output | 1 | One-cycle manual sync request toward the fabric |

## Verification
The bench builds two copies side by side: one with `EXT_SYNC_EN` = 1 and one with `EXT_SYNC_EN` = 0, both with `SYNC_STAGES` = 2. Both copies receive the same stimulus, so every strobe pattern also shows that the disabled build ignores the trigger controls. All sixteen combinations of the four strobes are swept twice, once starting from idle and once starting from armed, and each is followed by an external trigger edge. This covers the arm/disarm priority and the re-arm cases. The register and DAC clocks run at unrelated periods, so commands cross the domains at varying phases.

// File: rtl/dsync_pkg.sv
package dsync_pkg;

    typedef struct packed {
        logic disarm;
        logic arm;
        logic manual;
        logic sync;
    } sync_cmd_t;

    localparam int CMD_W = $bits(sync_cmd_t);

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;

    function automatic sync_cmd_t pack_cmd(input logic sync_b, input logic arm_b,
                                           input logic disarm_b, input logic manual_b);
        sync_cmd_t c;
        c.sync   = sync_b;
        c.arm    = arm_b;
        c.disarm = disarm_b;
        c.manual = manual_b;
        return c;
    endfunction

    function automatic logic cmd_any(input sync_cmd_t c);
        return |c;
    endfunction

endpackage

// File: rtl/dsync_bit_sync.sv
module dsync_bit_sync #(
    parameter int STAGES  = 2,
    parameter bit HAS_RST = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (HAS_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end else begin : g_free
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dsync_cmd_xfer.sv
module dsync_cmd_xfer
    import dsync_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      src_clk,
    input  logic      src_rst,
    input  sync_cmd_t src_cmd,
    input  logic      dst_clk,
    input  logic      dst_rst,
    output logic      dst_valid,
    output sync_cmd_t dst_cmd
);
    sync_cmd_t hold_q;
    logic      tgl_q;
    logic      tgl_s;
    logic      tgl_prev;

    // source: capture the command word, flip the request flag
    always_ff @(posedge src_clk) begin
        if (src_rst) begin
            hold_q <= '0;
            tgl_q  <= 1'b0;
        end else if (cmd_any(src_cmd)) begin
            hold_q <= src_cmd;
            tgl_q  <= ~tgl_q;
        end
    end

    // destination: synchroniser keeps tracking during reset so no stale edge
    dsync_bit_sync #(.STAGES(STAGES), .HAS_RST(1'b0)) u_tgl_sync (
        .clk (dst_clk),
        .rst (dst_rst),
        .d   (tgl_q),
        .q   (tgl_s)
    );

    always_ff @(posedge dst_clk) begin
        tgl_prev <= tgl_s;
    end

    always_ff @(posedge dst_clk) begin
        if (dst_rst) begin
            dst_valid <= 1'b0;
            dst_cmd   <= '0;
        end else begin
            dst_valid <= tgl_s ^ tgl_prev;
            dst_cmd   <= hold_q;
        end
    end
endmodule

// File: rtl/dsync_arm_fsm.sv
module dsync_arm_fsm
    import dsync_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_valid,
    input  sync_cmd_t cmd,
    input  logic      ext_rise,
    output logic      sync_pulse_o,
    output logic      manual_req_o,
    output logic      armed_o
);
    logic fire;
    logic sw_sync;

    assign sw_sync = cmd_valid && cmd.sync;

    generate
        if (EXT_EN) begin : g_ext
            arm_state_e state_q, state_d;
            logic       kill;

            assign kill = cmd_valid && cmd.disarm;

            always_comb begin
                state_d = state_q;
                fire    = 1'b0;
                if (kill) begin
                    state_d = ARM_IDLE;
                end else begin
                    if (state_q == ARM_WAIT && ext_rise) begin
                        fire    = 1'b1;
                        state_d = ARM_IDLE;
                    end
                    if (cmd_valid && cmd.arm) state_d = ARM_WAIT;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) state_q <= ARM_IDLE;
                else     state_q <= state_d;
            end

            always_ff @(posedge clk) begin
                if (rst) manual_req_o <= 1'b0;
                else     manual_req_o <= cmd_valid && cmd.manual;
            end

            assign armed_o = (state_q == ARM_WAIT);
        end else begin : g_noext
            logic unused_ext;
            assign unused_ext   = ext_rise ^ cmd.arm ^ cmd.disarm ^ cmd.manual;
            assign fire         = 1'b0;
            assign manual_req_o = 1'b0;
            assign armed_o      = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) sync_pulse_o <= 1'b0;
        else     sync_pulse_o <= sw_sync || fire;
    end
endmodule

// File: rtl/dac_sync_arm.sv
module dac_sync_arm
    import dsync_pkg::*;
#(
    parameter bit EXT_SYNC_EN = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic reg_clk,
    input  logic reg_rst,
    input  logic reg_sync_stb,
    input  logic reg_arm_stb,
    input  logic reg_disarm_stb,
    input  logic reg_manual_stb,
    output logic reg_waiting,
    input  logic dac_clk,
    input  logic dac_rst,
    input  logic ext_sync_in,
    output logic dac_sync_pulse,
    output logic dac_manual_req
);
    sync_cmd_t src_cmd;
    sync_cmd_t cmd_q;
    logic      cmd_valid;
    logic      ext_s;
    logic      ext_prev;
    logic      ext_rise;
    logic      armed;

    assign src_cmd = pack_cmd(reg_sync_stb, reg_arm_stb, reg_disarm_stb, reg_manual_stb);

    dsync_cmd_xfer #(.STAGES(SYNC_STAGES)) u_xfer (
        .src_clk   (reg_clk),
        .src_rst   (reg_rst),
        .src_cmd   (src_cmd),
        .dst_clk   (dac_clk),
        .dst_rst   (dac_rst),
        .dst_valid (cmd_valid),
        .dst_cmd   (cmd_q)
    );

    dsync_bit_sync #(.STAGES(SYNC_STAGES), .HAS_RST(1'b1)) u_ext_sync (
        .clk (dac_clk),
        .rst (dac_rst),
        .d   (ext_sync_in),
        .q   (ext_s)
    );

    always_ff @(posedge dac_clk) begin
        if (dac_rst) ext_prev <= 1'b1;
        else         ext_prev <= ext_s;
    end

    assign ext_rise = ext_s && !ext_prev;

    dsync_arm_fsm #(.EXT_EN(EXT_SYNC_EN)) u_fsm (
        .clk          (dac_clk),
        .rst          (dac_rst),
        .cmd_valid    (cmd_valid),
        .cmd          (cmd_q),
        .ext_rise     (ext_rise),
        .sync_pulse_o (dac_sync_pulse),
        .manual_req_o (dac_manual_req),
        .armed_o      (armed)
    );

    dsync_bit_sync #(.STAGES(SYNC_STAGES), .HAS_RST(1'b1)) u_wait_sync (
        .clk (reg_clk),
        .rst (reg_rst),
        .d   (armed),
        .q   (reg_waiting)
    );
endmodule

// File: rtl/dac_sync_arm_chk.sv
module dac_sync_arm_chk
    import dsync_pkg::*;
#(
    parameter bit EXT_EN = 1'b1
) (
    input logic      dac_clk,
    input logic      dac_rst,
    input logic      cmd_valid,
    input sync_cmd_t cmd_q,
    input logic      ext_rise,
    input logic      armed,
    input logic      dac_sync_pulse,
    input logic      dac_manual_req
);
    AST_SW_SYNC_FIRES: assert property (@(posedge dac_clk) disable iff (dac_rst)
        (cmd_valid && cmd_q.sync) |=> dac_sync_pulse); // R1

    AST_NO_STRAY_SYNC: assert property (@(posedge dac_clk) disable iff (dac_rst)
        dac_sync_pulse |-> ($past(cmd_valid && cmd_q.sync) || $past(armed && ext_rise))); // R8

    AST_TRIGGER_FIRES: assert property (@(posedge dac_clk) disable iff (dac_rst)
        (armed && ext_rise && !(cmd_valid && (cmd_q.disarm || cmd_q.arm)))
            |=> (dac_sync_pulse && !armed)); // R3

    AST_DISARM_WINS: assert property (@(posedge dac_clk) disable iff (dac_rst)
        (cmd_valid && cmd_q.disarm) |=> !armed); // R5

    AST_MANUAL_SOURCE: assert property (@(posedge dac_clk) disable iff (dac_rst)
        dac_manual_req |-> $past(cmd_valid && cmd_q.manual)); // R6

    AST_RESET_IDLE: assert property (@(posedge dac_clk)
        dac_rst |=> (!dac_sync_pulse && !dac_manual_req && !armed)); // R9

    generate
        if (EXT_EN) begin : g_on
            AST_ARM_TAKES: assert property (@(posedge dac_clk) disable iff (dac_rst)
                (cmd_valid && cmd_q.arm && !cmd_q.disarm) |=> armed); // R2
        end else begin : g_off
            AST_EXT_DISABLED: assert property (@(posedge dac_clk) disable iff (dac_rst)
                !armed && !dac_manual_req); // R7
        end
    endgenerate
endmodule

bind dac_sync_arm dac_sync_arm_chk #(.EXT_EN(EXT_SYNC_EN)) u_chk (
    .dac_clk        (dac_clk),
    .dac_rst        (dac_rst),
    .cmd_valid      (cmd_valid),
    .cmd_q          (cmd_q),
    .ext_rise       (ext_rise),
    .armed          (armed),
    .dac_sync_pulse (dac_sync_pulse),
    .dac_manual_req (dac_manual_req)
);

// File: tb/dac_sync_arm_tb_top.sv
`timescale 1ns/1ps
module dac_sync_arm_tb_top;
    logic reg_clk = 1'b0;
    logic dac_clk = 1'b0;
    logic reg_rst = 1'b1;
    logic dac_rst = 1'b1;
    logic s_sync = 1'b0, s_arm = 1'b0, s_dis = 1'b0, s_man = 1'b0;
    logic ext = 1'b0;

    logic wait_on, sync_on, man_on;
    logic wait_off, sync_off, man_off;

    int n_chk = 0;
    int n_bad = 0;
    int c_sync_on = 0, c_man_on = 0, c_sync_off = 0, c_man_off = 0, c_wide = 0;
    logic prev_sync_on = 1'b0, prev_sync_off = 1'b0, prev_man_on = 1'b0;

    always #10 reg_clk = ~reg_clk;   // 50 MHz
    always #7  dac_clk = ~dac_clk;

    dac_sync_arm #(.EXT_SYNC_EN(1'b1), .SYNC_STAGES(2)) dut_i (
        .reg_clk(reg_clk), .reg_rst(reg_rst), .reg_sync_stb(s_sync), .reg_arm_stb(s_arm),
        .reg_disarm_stb(s_dis), .reg_manual_stb(s_man), .reg_waiting(wait_on),
        .dac_clk(dac_clk), .dac_rst(dac_rst), .ext_sync_in(ext),
        .dac_sync_pulse(sync_on), .dac_manual_req(man_on));

    dac_sync_arm #(.EXT_SYNC_EN(1'b0), .SYNC_STAGES(2)) dut_off_i (
        .reg_clk(reg_clk), .reg_rst(reg_rst), .reg_sync_stb(s_sync), .reg_arm_stb(s_arm),
        .reg_disarm_stb(s_dis), .reg_manual_stb(s_man), .reg_waiting(wait_off),
        .dac_clk(dac_clk), .dac_rst(dac_rst), .ext_sync_in(ext),
        .dac_sync_pulse(sync_off), .dac_manual_req(man_off));

    always @(negedge dac_clk) begin
        if (sync_on === 1'b1)  c_sync_on++;
        if (man_on === 1'b1)   c_man_on++;
        if (sync_off === 1'b1) c_sync_off++;
        if (man_off === 1'b1)  c_man_off++;
        if ((sync_on === 1'b1 && prev_sync_on) || (sync_off === 1'b1 && prev_sync_off) ||
            (man_on === 1'b1 && prev_man_on)) c_wide++;
        prev_sync_on  = (sync_on === 1'b1);
        prev_sync_off = (sync_off === 1'b1);
        prev_man_on   = (man_on === 1'b1);
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_counts();
        c_sync_on = 0; c_man_on = 0; c_sync_off = 0; c_man_off = 0;
    endtask

    task automatic strobe(input logic [3:0] m); // m = {manual, disarm, arm, sync}
        @(posedge reg_clk); #1;
        s_sync = m[0]; s_arm = m[1]; s_dis = m[2]; s_man = m[3];
        @(posedge reg_clk); #1;
        {s_sync, s_arm, s_dis, s_man} = '0;
        repeat (14) @(posedge reg_clk);
        @(negedge reg_clk);
    endtask

    task automatic ext_edge();
        #3 ext = 1'b1;
        repeat (8) @(posedge reg_clk);
        #5 ext = 1'b0;
        repeat (8) @(posedge reg_clk);
        @(negedge reg_clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #3000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic exp_arm;
        repeat (12) @(posedge dac_clk);
        @(negedge reg_clk);
        // R9: outputs idle during reset
        chk("R9 sync in reset", c_sync_on + c_sync_off, 0);
        chk("R9 waiting in reset", int'(wait_on), 0);
        reg_rst = 1'b0; dac_rst = 1'b0;
        repeat (6) @(posedge reg_clk);
        @(negedge reg_clk);
        chk("R9 waiting after reset", int'(wait_on), 0);
        chk("R9 manual after reset", int'(man_on), 0);

        for (int pre = 0; pre < 2; pre++) begin
            for (int m = 0; m < 16; m++) begin
                if (pre == 1) begin
                    strobe(4'b0010);
                    chk("R2 waiting after arm", int'(wait_on), 1);
                end
                clr_counts();
                strobe(m[3:0]);
                exp_arm = m[2] ? 1'b0 : (m[1] || pre == 1);
                chk("R1 sync count", c_sync_on, int'(m[0]));
                chk("R6 manual count", c_man_on, int'(m[3]));
                chk("R5 waiting after command", int'(wait_on), int'(exp_arm));
                chk("R7 off sync count", c_sync_off, int'(m[0]));
                chk("R7 off manual", c_man_off, 0);
                chk("R7 off waiting", int'(wait_off), 0);
                clr_counts();
                ext_edge();
                // R3 armed fires, R4/R8 idle does not
                chk(exp_arm ? "R3 trigger pulse" : "R8 idle edge ignored", c_sync_on, int'(exp_arm));
                chk("R3 waiting cleared", int'(wait_on), 0);
                chk("R7 off ext ignored", c_sync_off, 0);
            end
        end

        // R4: disarm then trigger
        strobe(4'b0010);
        strobe(4'b0100);
        clr_counts();
        ext_edge();
        chk("R4 disarmed no pulse", c_sync_on, 0);

        // R3: level already high at arming does not fire
        ext = 1'b1;
        repeat (4) @(posedge reg_clk);
        clr_counts();
        strobe(4'b0010);
        chk("R3 high level no pulse", c_sync_on, 0);
        chk("R2 still waiting", int'(wait_on), 1);
        ext = 1'b0;
        repeat (6) @(posedge reg_clk);
        ext_edge();
        chk("R3 later edge fires", c_sync_on, 1);
        chk("R3 waiting cleared after fire", int'(wait_on), 0);

        // R9: DAC reset drops a pending arm
        strobe(4'b0010);
        @(posedge dac_clk); #1 dac_rst = 1'b1;
        clr_counts();
        repeat (10) @(posedge dac_clk);
        #1 dac_rst = 1'b0;
        repeat (6) @(posedge reg_clk);
        @(negedge reg_clk);
        chk("R9 arm lost by reset", int'(wait_on), 0);
        ext_edge();
        chk("R9 no pulse after reset", c_sync_on + c_man_on, 0);

        chk("R1 pulse width one cycle", c_wide, 0);
        finish_run();
    end
endmodule